// File: doc/BRIEF.md
# Serial-Loaded Cartridge Bank Mapper

This block is the bank controller of a game-console cartridge. The processor programs it over its ordinary write bus. Each write to the upper half of the address space carries one bit, and five such writes build a 5-bit word. The address of the fifth write chooses which internal register takes that word. A write with data bit 7 set cancels a load that is in progress and returns the program-ROM layout to its power-on arrangement.

From the four internal registers the block translates two address streams. The processor's reads above $8000 become a physical program-ROM address made of a 16 KB bank number and an offset. Reads in $6000-$7FFF become a work-RAM select and offset. The picture unit's pattern-table reads at $0000-$1FFF become a physical character-memory address made of a 4 KB bank number and an offset. The block also drives the nametable mirroring mode. Both translations are combinational. The memories themselves sit outside the block. Bank counts are parameters, and bank numbers wrap modulo those counts.

Top module: `sbank_mapper`

## Requirements
- R1: After reset the mirroring output is 0, the ROM layout is the one of R8 with selected bank 0, both character windows map bank 0, and the work-RAM select is low.
- R2: A write at an address with bit 15 set and data bit 7 set discards any partial load, so the next five bit-writes form a fresh word.
- R3: The write of R2 sets ROM layout field (control bits 3:2) to 3 and keeps the mirroring field (bits 1:0) and the character mode bit (bit 4).
- R4: Each write at an address with bit 15 set and data bit 7 clear shifts in data bit 0, least significant bit first. The fifth one commits the word to a target chosen only by address bits 14:13 of that fifth write: 0 control, 1 character window 0, 2 character window 1, 3 program register. Writes below $8000 leave the load untouched.
- R5: The mirroring output equals control bits 1:0, with 0 single-screen low, 1 single-screen high, 2 vertical and 3 horizontal.
- R6: In ROM layouts 0 and 1, $8000-$BFFF maps the selected bank with bit 0 cleared, and $C000-$FFFF maps that bank plus one.
- R7: In ROM layout 2, $8000-$BFFF maps bank 0 and $C000-$FFFF maps the selected bank.
- R8: In ROM layout 3, $8000-$BFFF maps the selected bank and $C000-$FFFF maps the last bank.
- R9: With control bit 4 set, the two character windows ($0000-$0FFF and $1000-$1FFF) are loaded independently by targets 1 and 2.
- R10: With control bit 4 clear, a target-1 word with bit 0 cleared goes to the low window and that value plus one goes to the high window. A target-2 word changes nothing.
- R11: Program register bits 3:0 select the 16 KB bank and bit 4 enables work RAM. The RAM select is high only for $6000-$7FFF while it is enabled, and the RAM offset is address bits 12:0. The ROM select is address bit 15.
- R12: Program and character bank numbers wrap modulo PRG_BANKS and CHR_BANKS, and the last bank of R8 is PRG_BANKS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Processor write strobe, one write per cycle it is high |
| wr_addr | input | 16 | Processor write address |
| wr_data | input | 8 | Processor write data |
| cpu_addr | input | 16 | Processor read address to translate |
| ppu_addr | input | 13 | Pattern-table address to translate |
| prg_rom_cs | output | 1 | Program ROM select |
| prg_rom_addr | output | PRG_AW (17) | Physical program-ROM address: bank and 14-bit offset |
| prg_ram_cs | output | 1 | Work-RAM select |
| prg_ram_addr | output | 13 | Work-RAM offset |
| chr_addr | output | CHR_AW (17) | Physical character address: bank and 12-bit offset |
| mirror_mode | output | 2 | Nametable mirroring mode |

## Verification
The hardest case to reach from the ports is a load that is interrupted. The word must be rebuilt from scratch after a cancel write. It must also land in the register named by the fifth address, even when the earlier four writes named a different register or were interleaved with writes below $8000. Directed sequences build each of these cases on purpose. A long random run then mixes cancel writes, out-of-window writes and bit-writes at random targets. Every step of that run is compared against a bench model of the shift protocol and of the bank rules.

// File: rtl/sbank_pkg.sv
package sbank_pkg;

    localparam int unsigned LOAD_BITS = 5;
    localparam int unsigned LOAD_CW   = $clog2(LOAD_BITS);

    typedef enum logic [1:0] {
        MIR_ONE_LO = 2'd0,
        MIR_ONE_HI = 2'd1,
        MIR_VERT   = 2'd2,
        MIR_HORZ   = 2'd3
    } mirror_e;

    typedef enum logic [1:0] {
        TGT_CTRL = 2'd0,
        TGT_CHR0 = 2'd1,
        TGT_CHR1 = 2'd2,
        TGT_PRG  = 2'd3
    } target_e;

    typedef enum logic [1:0] {
        LAY_WIDE0 = 2'd0,
        LAY_WIDE1 = 2'd1,
        LAY_FIXLO = 2'd2,
        LAY_FIXHI = 2'd3
    } layout_e;

    typedef struct packed {
        logic    chr_4k;
        layout_e layout;
        mirror_e mirror;
    } ctrl_t;

    typedef struct packed {
        logic       ram_en;
        logic [3:0] bank;
    } prg_reg_t;

    typedef struct packed {
        logic                 valid;
        target_e              target;
        logic [LOAD_BITS-1:0] value;
    } commit_t;

    localparam ctrl_t CTRL_RESET = '{chr_4k: 1'b0, layout: LAY_FIXHI, mirror: MIR_ONE_LO};

    function automatic logic in_reg_window(input logic [15:0] a);
        return a[15];
    endfunction

    function automatic logic in_ram_window(input logic [15:0] a);
        return a[15:13] == 3'b011;
    endfunction

    function automatic target_e decode_target(input logic [15:0] a);
        return target_e'(a[14:13]);
    endfunction

endpackage

// File: rtl/sbank_loader.sv
module sbank_loader
    import sbank_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [15:0]        wr_addr,
    input  logic               bit_in,
    input  logic               cancel,
    output commit_t            commit,
    output logic               force_layout,
    output logic [LOAD_CW-1:0] load_cnt
);

    localparam logic [LOAD_CW-1:0] LAST = LOAD_CW'(LOAD_BITS - 1);

    logic [LOAD_BITS-1:0] sr_q;
    logic [LOAD_BITS-1:0] sr_next;
    logic [LOAD_CW-1:0]   cnt_q;
    logic                 hit;

    assign hit     = wr_en && in_reg_window(wr_addr);
    assign sr_next = {bit_in, sr_q[LOAD_BITS-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (hit) begin
            if (cancel || cnt_q == LAST) begin
                sr_q  <= '0;
                cnt_q <= '0;
            end else begin
                sr_q  <= sr_next;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        commit.valid  = hit && !cancel && (cnt_q == LAST);
        commit.target = decode_target(wr_addr);
        commit.value  = sr_next;
    end

    assign force_layout = hit && cancel;
    assign load_cnt     = cnt_q;

endmodule

// File: rtl/sbank_regfile.sv
module sbank_regfile
    import sbank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  commit_t              commit,
    input  logic                 force_layout,
    output ctrl_t                ctrl_q,
    output logic [LOAD_BITS-1:0] chr_lo_q,
    output logic [LOAD_BITS-1:0] chr_hi_q,
    output prg_reg_t             prg_q
);

    logic [LOAD_BITS-1:0] pair_base;

    assign pair_base = {commit.value[LOAD_BITS-1:1], 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= CTRL_RESET;
            chr_lo_q <= '0;
            chr_hi_q <= '0;
            prg_q    <= '0;
        end else begin
            if (force_layout) begin
                ctrl_q.layout <= LAY_FIXHI;
            end
            if (commit.valid) begin
                unique case (commit.target)
                    TGT_CTRL: ctrl_q <= ctrl_t'(commit.value);
                    TGT_CHR0: begin
                        if (ctrl_q.chr_4k) begin
                            chr_lo_q <= commit.value;
                        end else begin
                            chr_lo_q <= pair_base;
                            chr_hi_q <= pair_base | LOAD_BITS'(1);
                        end
                    end
                    TGT_CHR1: begin
                        if (ctrl_q.chr_4k) begin
                            chr_hi_q <= commit.value;
                        end
                    end
                    TGT_PRG:  prg_q <= prg_reg_t'(commit.value);
                    default:  ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sbank_prg_map.sv
module sbank_prg_map
    import sbank_pkg::*;
#(
    parameter int unsigned PRG_BANKS = 8,
    localparam int unsigned PRG_BW  = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1,
    localparam int unsigned PRG_AW  = PRG_BW + 14
)(
    input  layout_e           layout,
    input  prg_reg_t          prg,
    input  logic [15:0]       cpu_addr,
    output logic              rom_cs,
    output logic [PRG_AW-1:0] rom_addr,
    output logic              ram_cs,
    output logic [12:0]       ram_addr
);

    localparam int unsigned LAST_BANK = PRG_BANKS - 1;

    int unsigned      raw_bank;
    logic [PRG_BW-1:0] bank;
    logic             upper;

    assign upper = cpu_addr[14];

    always_comb begin
        unique case (layout)
            LAY_WIDE0, LAY_WIDE1:
                raw_bank = 32'({prg.bank[3:1], 1'b0}) + 32'(upper);
            LAY_FIXLO:
                raw_bank = upper ? 32'(prg.bank) : 32'd0;
            LAY_FIXHI:
                raw_bank = upper ? LAST_BANK : 32'(prg.bank);
            default:
                raw_bank = 32'd0;
        endcase
        bank = PRG_BW'(raw_bank % PRG_BANKS);
    end

    assign rom_cs   = cpu_addr[15];
    assign rom_addr = {bank, cpu_addr[13:0]};
    assign ram_cs   = in_ram_window(cpu_addr) && prg.ram_en;
    assign ram_addr = cpu_addr[12:0];

endmodule

// File: rtl/sbank_chr_map.sv
module sbank_chr_map
    import sbank_pkg::*;
#(
    parameter int unsigned CHR_BANKS = 32,
    localparam int unsigned CHR_BW  = (CHR_BANKS > 1) ? $clog2(CHR_BANKS) : 1,
    localparam int unsigned CHR_AW  = CHR_BW + 12
)(
    input  logic [LOAD_BITS-1:0] chr_lo,
    input  logic [LOAD_BITS-1:0] chr_hi,
    input  logic [12:0]          ppu_addr,
    output logic [CHR_AW-1:0]    chr_addr
);

    logic [LOAD_BITS-1:0] win_reg  [2];
    logic [CHR_BW-1:0]    win_bank [2];

    assign win_reg[0] = chr_lo;
    assign win_reg[1] = chr_hi;

    for (genvar w = 0; w < 2; w++) begin : g_win
        assign win_bank[w] = CHR_BW'(32'(win_reg[w]) % CHR_BANKS);
    end

    assign chr_addr = {win_bank[ppu_addr[12]], ppu_addr[11:0]};

endmodule

// File: rtl/sbank_mapper.sv
module sbank_mapper
    import sbank_pkg::*;
#(
    parameter int unsigned PRG_BANKS = 8,
    parameter int unsigned CHR_BANKS = 32,
    localparam int unsigned PRG_BW  = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1,
    localparam int unsigned CHR_BW  = (CHR_BANKS > 1) ? $clog2(CHR_BANKS) : 1,
    localparam int unsigned PRG_AW  = PRG_BW + 14,
    localparam int unsigned CHR_AW  = CHR_BW + 12
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [15:0]       wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [15:0]       cpu_addr,
    input  logic [12:0]       ppu_addr,
    output logic              prg_rom_cs,
    output logic [PRG_AW-1:0] prg_rom_addr,
    output logic              prg_ram_cs,
    output logic [12:0]       prg_ram_addr,
    output logic [CHR_AW-1:0] chr_addr,
    output logic [1:0]        mirror_mode
);

    commit_t              commit;
    logic                 force_layout;
    logic [LOAD_CW-1:0]   load_cnt;
    ctrl_t                ctrl_q;
    logic [LOAD_BITS-1:0] chr_lo_q;
    logic [LOAD_BITS-1:0] chr_hi_q;
    prg_reg_t             prg_q;
    logic                 wr_unused;

    assign wr_unused = ^{wr_addr[12:0], wr_data[6:1]};

    sbank_loader u_loader (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .bit_in       (wr_data[0]),
        .cancel       (wr_data[7]),
        .commit       (commit),
        .force_layout (force_layout),
        .load_cnt     (load_cnt)
    );

    sbank_regfile u_regs (
        .clk          (clk),
        .rst          (rst),
        .commit       (commit),
        .force_layout (force_layout),
        .ctrl_q       (ctrl_q),
        .chr_lo_q     (chr_lo_q),
        .chr_hi_q     (chr_hi_q),
        .prg_q        (prg_q)
    );

    sbank_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
        .layout   (ctrl_q.layout),
        .prg      (prg_q),
        .cpu_addr (cpu_addr),
        .rom_cs   (prg_rom_cs),
        .rom_addr (prg_rom_addr),
        .ram_cs   (prg_ram_cs),
        .ram_addr (prg_ram_addr)
    );

    sbank_chr_map #(.CHR_BANKS(CHR_BANKS)) u_chr (
        .chr_lo   (chr_lo_q),
        .chr_hi   (chr_hi_q),
        .ppu_addr (ppu_addr),
        .chr_addr (chr_addr)
    );

    assign mirror_mode = ctrl_q.mirror;

endmodule

// File: rtl/sbank_mapper_chk.sv
module sbank_mapper_chk #(
    parameter int unsigned PRG_BANKS = 8,
    parameter int unsigned PRG_AW    = 17
)(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [15:0]       wr_addr,
    input logic [7:0]        wr_data,
    input logic [2:0]        load_cnt,
    input logic              commit_valid,
    input logic [1:0]        commit_target,
    input logic [4:0]        ctrl,
    input logic [4:0]        chr_lo,
    input logic [4:0]        chr_hi,
    input logic [15:0]       cpu_addr,
    input logic [PRG_AW-1:0] prg_rom_addr,
    input logic              prg_ram_cs
);

    localparam logic [PRG_AW-15:0] LAST = (PRG_AW-14)'(PRG_BANKS - 1);

    logic cancel_wr;
    logic bit_wr;

    assign cancel_wr = wr_en && wr_addr[15] && wr_data[7];
    assign bit_wr    = wr_en && wr_addr[15] && !wr_data[7];

    p_cancel_layout_r3: assert property (@(posedge clk) disable iff (rst)
        cancel_wr |=> (ctrl[3:2] == 2'b11 && ctrl[4] == $past(ctrl[4])
                       && ctrl[1:0] == $past(ctrl[1:0])));

    p_cancel_count_r2: assert property (@(posedge clk) disable iff (rst)
        cancel_wr |=> load_cnt == 3'd0);

    p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
        (bit_wr && load_cnt < 3'd4) |=> load_cnt == 3'($past(load_cnt) + 3'd1));

    p_commit_wraps_r4: assert property (@(posedge clk) disable iff (rst)
        commit_valid |=> load_cnt == 3'd0);

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr[15]) |=> $stable(load_cnt));

    p_chr1_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (commit_valid && commit_target == 2'd2 && !ctrl[4]) |=> $stable(chr_hi));

    p_chr_pair_r10: assert property (@(posedge clk) disable iff (rst)
        (commit_valid && commit_target == 2'd1 && !ctrl[4])
            |=> (!chr_lo[0] && chr_hi == 5'(chr_lo + 5'd1)));

    p_last_bank_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl[3:2] == 2'b11 && cpu_addr[15:14] == 2'b11)
            |-> prg_rom_addr[PRG_AW-1:14] == LAST);

    p_ram_window_r11: assert property (@(posedge clk) disable iff (rst)
        prg_ram_cs |-> cpu_addr[15:13] == 3'b011);

endmodule

bind sbank_mapper sbank_mapper_chk #(.PRG_BANKS(PRG_BANKS), .PRG_AW(PRG_AW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .load_cnt      (load_cnt),
    .commit_valid  (commit.valid),
    .commit_target (commit.target),
    .ctrl          (ctrl_q),
    .chr_lo        (chr_lo_q),
    .chr_hi        (chr_hi_q),
    .cpu_addr      (cpu_addr),
    .prg_rom_addr  (prg_rom_addr),
    .prg_ram_cs    (prg_ram_cs)
);

// File: tb/sbank_mapper_bench.sv
module sbank_mapper_bench;

    localparam int PRG_BANKS = 8;
    localparam int CHR_BANKS = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] cpu_addr = '0;
    logic [12:0] ppu_addr = '0;
    logic        prg_rom_cs;
    logic [16:0] prg_rom_addr;
    logic        prg_ram_cs;
    logic [12:0] prg_ram_addr;
    logic [16:0] chr_addr;
    logic [1:0]  mirror_mode;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench model of the programmable state
    logic [4:0] m_ctl, m_lo, m_hi, m_prg, m_sr;
    int         m_cnt;

    always #5 clk = ~clk;

    sbank_mapper u_sbank_mapper (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cpu_addr(cpu_addr), .ppu_addr(ppu_addr),
        .prg_rom_cs(prg_rom_cs), .prg_rom_addr(prg_rom_addr),
        .prg_ram_cs(prg_ram_cs), .prg_ram_addr(prg_ram_addr),
        .chr_addr(chr_addr), .mirror_mode(mirror_mode)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic model_reset();
        m_ctl = 5'b01100; m_lo = 0; m_hi = 0; m_prg = 0; m_sr = 0; m_cnt = 0;
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        logic [4:0] v;
        if (!a[15]) return;
        if (d[7]) begin
            m_sr = 0; m_cnt = 0; m_ctl[3:2] = 2'b11;
            return;
        end
        v = {d[0], m_sr[4:1]};
        if (m_cnt == 4) begin
            case (a[14:13])
                2'd0: m_ctl = v;
                2'd1: if (m_ctl[4]) m_lo = v;
                      else begin m_lo = {v[4:1], 1'b0}; m_hi = {v[4:1], 1'b1}; end
                2'd2: if (m_ctl[4]) m_hi = v;
                default: m_prg = v;
            endcase
            m_sr = 0; m_cnt = 0;
        end else begin
            m_sr = v; m_cnt++;
        end
    endtask

    function automatic int exp_prg_bank(input logic [15:0] a);
        int raw;
        case (m_ctl[3:2])
            2'd0, 2'd1: raw = int'({m_prg[3:1], 1'b0}) + int'(a[14]);
            2'd2:       raw = a[14] ? int'(m_prg[3:0]) : 0;
            default:    raw = a[14] ? PRG_BANKS - 1 : int'(m_prg[3:0]);
        endcase
        return raw % PRG_BANKS;
    endfunction

    function automatic int exp_chr(input logic [12:0] a);
        int b;
        b = int'(a[12] ? m_hi : m_lo) % CHR_BANKS;
        return b * 4096 + int'(a[11:0]);
    endfunction

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        model_write(a, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load5(input logic [15:0] a, input logic [4:0] v);
        for (int i = 0; i < 5; i++) wr(a, {7'd0, v[i]});
    endtask

    task automatic chk_cpu(input logic [15:0] a, input string tag);
        logic ram_exp;
        cpu_addr = a;
        #1;
        check(tag, prg_rom_cs, a[15]);
        if (a[15]) check(tag, prg_rom_addr, exp_prg_bank(a) * 16384 + int'(a[13:0]));
        ram_exp = (a[15:13] == 3'b011) && m_prg[4];
        check("R11", prg_ram_cs, ram_exp);
        if (ram_exp) check("R11", prg_ram_addr, a[12:0]);
    endtask

    task automatic chk_ppu(input logic [12:0] a, input string tag);
        ppu_addr = a;
        #1;
        check(tag, chr_addr, exp_chr(a));
    endtask

    task automatic chk_mirror(input string tag);
        #1;
        check(tag, mirror_mode, m_ctl[1:0]);
    endtask

    function automatic string lay_tag();
        case (m_ctl[3:2])
            2'd0, 2'd1: return "R6";
            2'd2:       return "R7";
            default:    return "R8";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        logic [15:0] a;
        logic [7:0]  d;
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk_mirror("R1");
        chk_cpu(16'h8123, "R1");
        chk_cpu(16'hC456, "R1");
        check("R1", prg_rom_addr[16:14], 3'd7);
        chk_cpu(16'h6010, "R1");
        check("R1", prg_ram_cs, 1'b0);
        chk_ppu(13'h0055, "R1");
        chk_ppu(13'h1055, "R1");

        // R5 R9 R6: 4 KB character mode, wide layout, vertical mirroring
        load5(16'h8000, 5'b1_00_10);
        chk_mirror("R5");
        check("R5", mirror_mode, 2'd2);
        load5(16'hA000, 5'd3);
        load5(16'hC000, 5'd9);
        chk_ppu(13'h0010, "R9");
        chk_ppu(13'h1020, "R9");
        check("R9", chr_addr, 17'(9 * 4096 + 'h20));
        load5(16'hE000, 5'd5);
        chk_cpu(16'h8001, "R6");
        check("R6", prg_rom_addr[16:14], 3'd4);
        chk_cpu(16'hC001, "R6");
        check("R6", prg_rom_addr[16:14], 3'd5);

        // R7 fixed low layout, horizontal mirroring
        load5(16'h9FFF, 5'b1_10_11);
        chk_mirror("R5");
        chk_cpu(16'h8100, "R7");
        check("R7", prg_rom_addr[16:14], 3'd0);
        chk_cpu(16'hC100, "R7");
        check("R7", prg_rom_addr[16:14], 3'd5);

        // R8 fixed high layout
        load5(16'h8000, 5'b1_11_01);
        chk_cpu(16'h8200, "R8");
        check("R8", prg_rom_addr[16:14], 3'd5);
        chk_cpu(16'hFFFF, "R8");
        check("R8", prg_rom_addr[16:14], 3'd7);

        // R11 work RAM enable and window edges
        load5(16'hE000, 5'b1_0010);
        chk_cpu(16'h6ABC, "R11");
        check("R11", prg_ram_cs, 1'b1);
        chk_cpu(16'h5FFF, "R11");
        chk_cpu(16'h7FFF, "R11");
        chk_cpu(16'h8000, "R11");
        check("R11", prg_ram_cs, 1'b0);

        // R12 bank wrap
        load5(16'hE000, 5'd13);
        chk_cpu(16'h8000, "R12");
        check("R12", prg_rom_addr[16:14], 3'd5);

        // R10 8 KB character mode
        load5(16'h8000, 5'b0_11_00);
        load5(16'hA000, 5'd7);
        chk_ppu(13'h0000, "R10");
        check("R10", chr_addr[16:12], 5'd6);
        chk_ppu(13'h1000, "R10");
        check("R10", chr_addr[16:12], 5'd7);
        load5(16'hC000, 5'd20);
        chk_ppu(13'h1000, "R10");
        check("R10", chr_addr[16:12], 5'd7);

        // R2 partial load discarded by cancel write
        wr(16'hE000, 8'h01);
        wr(16'hE000, 8'h01);
        wr(16'hF000, 8'h80);
        load5(16'hE000, 5'd3);
        chk_cpu(16'h8000, "R2");
        check("R2", prg_rom_addr[16:14], 3'd3);

        // R3 cancel forces fixed high layout, keeps mirroring and character mode
        load5(16'h8000, 5'b1_00_10);
        wr(16'hA000, 8'hFF);
        chk_mirror("R3");
        check("R3", mirror_mode, 2'd2);
        chk_cpu(16'hC000, "R3");
        check("R3", prg_rom_addr[16:14], 3'd7);
        load5(16'hC000, 5'd4);
        chk_ppu(13'h1000, "R3");
        check("R3", chr_addr[16:12], 5'd4);

        // R4 target taken from fifth address only; low writes ignored mid-load
        wr(16'hE000, 8'h00);
        wr(16'hE000, 8'h01);
        wr(16'h6000, 8'h01);
        wr(16'h2000, 8'h00);
        wr(16'hE000, 8'h01);
        wr(16'hE000, 8'h00);
        wr(16'hA123, 8'h01);
        chk_ppu(13'h0001, "R4");
        check("R4", chr_addr[16:12], 5'b10110);
        chk_cpu(16'h8000, "R4");
        check("R4", prg_rom_addr[16:14], 3'd3);

        // random mix
        for (int it = 0; it < 1500; it++) begin
            a = 16'($urandom);
            if (($urandom % 8) != 0) a[15] = 1'b1;
            d = 8'($urandom);
            if (($urandom % 12) != 0) d[7] = 1'b0;
            wr(a, d);
            chk_mirror("R5");
            chk_cpu(16'($urandom) | 16'h8000, lay_tag());
            chk_cpu({3'b011, 13'($urandom)}, "R11");
            chk_ppu(13'($urandom), m_ctl[4] ? "R9" : "R10");
        end

        done = 1;
        summary();
    end

endmodule